// File: doc/BRIEF.md
# Parallel One-Dimensional Sliding-Window Generator

This block turns a stream of pixels into a stream of convolution windows for a one-dimensional layer. Every input beat holds one whole pixel, with all of its channels side by side. When the block has collected as many pixels as the kernel is wide, it presents the full window as one wide output beat. The compute stage behind it can then take every element of the window in a single cycle. Stride and dilation are both fixed at one, and there is no padding. An image of `IN_W` pixels therefore yields `IN_W - KW + 1` windows.

Both sides use valid/ready handshakes in the AXI4-Stream style. A `start` pulse in the idle state latches a run-time image count. The block then processes that many images one after another. It clears its window store at the start of each image and returns to idle after the last window of the last image.

The controller has three states:

- **ST_IDLE**: nothing is accepted and nothing is offered.
- **ST_LOAD**: pixels are accepted and no window is offered.
- **ST_EMIT**: a complete window is offered. A new pixel is taken only in the same cycle that the current window is handed over.

The transitions are:

- **T_START**: ST_IDLE to ST_LOAD, on `start` with a non-zero count.
- **T_FULL**: ST_LOAD to ST_EMIT, when the pixel that completes the first or next window is accepted.
- **T_STEP**: ST_EMIT to ST_EMIT, when a window leaves and a pixel enters in the same cycle.
- **T_STARVE**: ST_EMIT to ST_LOAD, when a window leaves with no pixel and the image still has pixels.
- **T_NEXT_IMG**: ST_EMIT to ST_LOAD with the window cleared, when the last window of an image leaves and images remain.
- **T_LAST_IMG**: ST_EMIT to ST_IDLE, when the last window of the last image leaves.

Top module: `win1d_par_gen`

## Requirements
- R1: While reset is held and in the first cycle after reset, `in_ready` and `out_valid` are both 0.
- R2: A `start` pulse in idle with `img_count` greater than 0 raises `in_ready` in the next cycle. A `start` with `img_count` equal to 0 leaves the block idle: `in_ready` stays 0.
- R3: In each window, pixel slot j occupies `out_data[j*CH*PREC +: CH*PREC]`. Slot 0 holds the oldest pixel and slot KW-1 the newest. Within a pixel, channel c occupies bits `c*PREC +: PREC`, as on the input. Window n of an image holds pixels n to n+KW-1 of that image.
- R4: No window is offered in an image until KW pixels of that image have been accepted.
- R5: When window n of an image is handed over, exactly KW+n pixels of that image have been accepted. Each image yields exactly IN_W-KW+1 windows.
- R6: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0. In the next cycle `out_valid` is still 1 and `out_data` is unchanged.
- R7: Windows of every image after the first contain only pixels of that image. No pixel of an earlier image appears in them.
- R8: After the last window of the last image, the block is idle: `in_ready` and `out_valid` are 0.
- R9: With input always valid and output always ready, each image spans exactly KW+(IN_W-KW+1) cycles. The count runs from the cycle of its first pixel handshake to the cycle of its last window handshake, both included.
- R10: A `start` pulse while images are in progress is ignored. The number of images processed stays the one latched at the original start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a run; honoured only when idle |
| img_count | input | IMG_W | Number of images in the run, sampled with `start` |
| in_valid | input | 1 | Input pixel is valid |
| in_ready | output | 1 | Block accepts the input pixel |
| in_data | input | CH*PREC | One pixel, channel 0 in the lowest bits |
| out_valid | output | 1 | A complete window is offered |
| out_ready | input | 1 | Downstream accepts the window |
| out_data | output | KW*CH*PREC | Window, oldest pixel in the lowest slot |

## Verification
The block is driven with four handshake patterns on a small configuration:

- **Free flow** (both sides always ready). This isolates the cycle count of R9 and shows that the fill phase really lasts KW beats.
- **Irregular gaps on both sides.** This separates the T_STEP and T_STARVE paths, since a window can leave either with or without a new pixel in the same cycle.
- **Heavy output backpressure.** This holds windows for several cycles and exposes any pixel taken, or window altered, during a stall.
- **Steady partial backpressure.**

Runs of several images show whether the window is cleared between images. Zero-count and mid-run start pulses show whether the count latch is guarded.

// File: rtl/win1d_pkg.sv
package win1d_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_EMIT = 2'd2
    } win_state_e;

endpackage

// File: rtl/win1d_shift_reg.sv
module win1d_shift_reg #(
    parameter int KW    = 3,
    parameter int PIX_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                shift,
    input  logic [PIX_W-1:0]    pix_in,
    output logic [KW*PIX_W-1:0] window
);

    localparam int WIN_W = KW * PIX_W;

    logic [WIN_W-1:0] win_q;

    generate
        if (KW == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n || clr) begin
                    win_q <= '0;
                end else if (shift) begin
                    win_q <= pix_in;
                end
            end
        end else begin : g_chain
            // newest pixel enters the top slot, the rest move one slot down
            always_ff @(posedge clk) begin
                if (!rst_n || clr) begin
                    win_q <= '0;
                end else if (shift) begin
                    win_q <= {pix_in, win_q[WIN_W-1:PIX_W]};
                end
            end
        end
    endgenerate

    assign window = win_q;

endmodule

// File: rtl/win1d_ctrl.sv
module win1d_ctrl
    import win1d_pkg::*;
#(
    parameter int KW    = 3,
    parameter int IN_W  = 16,
    parameter int IMG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [IMG_W-1:0] img_count,
    input  logic             in_valid,
    input  logic             out_ready,
    output logic             in_ready,
    output logic             out_valid,
    output logic             shift,
    output logic             clr
);

    localparam int CNT_W = $clog2(IN_W + 1);
    localparam logic [CNT_W-1:0] FULL_M1  = CNT_W'(KW - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(KW);
    localparam logic [CNT_W-1:0] LAST_PIX = CNT_W'(IN_W);
    localparam logic [IMG_W-1:0] ONE_IMG  = IMG_W'(1);

    win_state_e       state, state_nx;
    logic [CNT_W-1:0] in_cnt;
    logic [IMG_W-1:0] img_left;
    logic             in_fire, out_fire, pix_done, img_end, go;

    assign in_fire  = in_valid && in_ready;
    assign out_fire = out_valid && out_ready;
    assign pix_done = (in_cnt == LAST_PIX);
    assign img_end  = (state == ST_EMIT) && out_fire && pix_done;
    assign go       = (state == ST_IDLE) && start && (img_count != '0);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (go) state_nx = ST_LOAD;                         // T_START
            end
            ST_LOAD: begin
                if (in_fire && in_cnt >= FULL_M1) state_nx = ST_EMIT; // T_FULL
            end
            ST_EMIT: begin
                if (out_fire) begin
                    if (in_fire) begin
                        state_nx = ST_EMIT;                         // T_STEP
                    end else if (pix_done) begin
                        state_nx = (img_left == ONE_IMG) ? ST_IDLE  // T_LAST_IMG
                                                         : ST_LOAD; // T_NEXT_IMG
                    end else begin
                        state_nx = ST_LOAD;                         // T_STARVE
                    end
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        unique case (state)
            ST_IDLE: begin
                in_ready  = 1'b0;
                out_valid = 1'b0;
            end
            ST_LOAD: begin
                in_ready  = 1'b1;
                out_valid = 1'b0;
            end
            ST_EMIT: begin
                out_valid = 1'b1;
                in_ready  = out_ready && !pix_done;
            end
            default: begin
                in_ready  = 1'b0;
                out_valid = 1'b0;
            end
        endcase
    end

    assign shift = in_fire;
    assign clr   = go || img_end;

    // pixel and image counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_cnt   <= '0;
            img_left <= '0;
        end else begin
            if (go || img_end) begin
                in_cnt <= '0;
            end else if (in_fire) begin
                in_cnt <= in_cnt + 1'b1;
            end
            if (go) begin
                img_left <= img_count;
            end else if (img_end) begin
                img_left <= img_left - 1'b1;
            end
        end
    end

    // R6: a held window blocks new pixels and stays offered
    a_r6_no_take: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready);
    a_r6_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid);
    // R4: no window before KW pixels of the image are in
    a_r4_no_early: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> in_cnt >= FULL_CNT);
    // R5: a window leaving without a new pixel is not repeated
    a_r5_no_dup: assert property (@(posedge clk) disable iff (!rst_n)
        out_fire && !in_fire |=> !out_valid);
    // R5: pixel counter never passes the image width
    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        in_cnt <= LAST_PIX);
    // R10: start during a run does not reload the image count
    a_r10_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) && start && !img_end |=> $stable(img_left));

endmodule

// File: rtl/win1d_par_gen.sv
module win1d_par_gen #(
    parameter int KW    = 3,
    parameter int CH    = 4,
    parameter int PREC  = 8,
    parameter int IN_W  = 16,
    parameter int IMG_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [IMG_W-1:0]       img_count,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [CH*PREC-1:0]     in_data,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [KW*CH*PREC-1:0]  out_data
);

    localparam int PIX_W = CH * PREC;
    localparam int WIN_W = KW * PIX_W;

    logic shift, clr;

    win1d_ctrl #(
        .KW    (KW),
        .IN_W  (IN_W),
        .IMG_W (IMG_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .img_count (img_count),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .shift     (shift),
        .clr       (clr)
    );

    win1d_shift_reg #(
        .KW    (KW),
        .PIX_W (PIX_W)
    ) u_win (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .shift  (shift),
        .pix_in (in_data),
        .window (out_data)
    );

    // R6: a stalled window keeps its contents
    a_r6_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> $stable(out_data));
    // R3: an accepted pixel lands in the newest slot
    a_r3_newest_slot: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_data[WIN_W-1 -: PIX_W] == $past(in_data));

endmodule

// File: tb/tb_win1d_par_gen.sv
module tb_win1d_par_gen;

    localparam int KW    = 3;
    localparam int CH    = 2;
    localparam int PREC  = 4;
    localparam int IN_W  = 6;
    localparam int IMG_W = 8;
    localparam int OUT_W = IN_W - KW + 1;
    localparam int PIX_W = CH * PREC;
    localparam int WIN_W = KW * PIX_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [IMG_W-1:0] img_count = '0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [PIX_W-1:0] in_data = '0;
    logic             out_valid;
    logic             out_ready = 1'b0;
    logic [WIN_W-1:0] out_data;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    win1d_par_gen #(
        .KW(KW), .CH(CH), .PREC(PREC), .IN_W(IN_W), .IMG_W(IMG_W)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .img_count(img_count),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [PREC-1:0] elem(input int img, input int p, input int c);
        return PREC'((img * 7 + p * 3 + c * 5 + 1) % (1 << PREC));
    endfunction

    function automatic logic [PIX_W-1:0] pixel(input int img, input int p);
        logic [PIX_W-1:0] v = '0;
        for (int c = 0; c < CH; c++) v[c*PREC +: PREC] = elem(img, p, c);
        return v;
    endfunction

    function automatic logic [WIN_W-1:0] window(input int img, input int n);
        logic [WIN_W-1:0] v = '0;
        for (int j = 0; j < KW; j++) v[j*PIX_W +: PIX_W] = pixel(img, n + j);
        return v;
    endfunction

    function automatic bit gate_in(input int g, input int pat);
        case (pat)
            0: return 1'b1;
            1: return ((g * 5 + 1) % 3) != 0;
            2: return (g % 2) == 0;
            default: return 1'b1;
        endcase
    endfunction

    function automatic bit gate_out(input int g, input int pat);
        case (pat)
            0: return 1'b1;
            1: return (g % 4) != 1;
            2: return (g % 5) == 0;
            default: return (g % 3) != 0;
        endcase
    endfunction

    task automatic run(input int n, input int pat, input bit poke, input bit timing);
        int img_in = 0, p = 0, img_out = 0, w = 0, g = 0, first_in = 0, acc = 0;
        bit prev_stall = 1'b0;
        logic [WIN_W-1:0] prev_data = '0;
        @(negedge clk);
        start = 1'b1;
        img_count = IMG_W'(n);
        @(negedge clk);
        start = 1'b0;
        while (img_out < n && g < 3000) begin
            in_valid  = (img_in < n) && gate_in(g, pat);
            in_data   = pixel(img_in, p);
            out_ready = gate_out(g, pat);
            start     = poke && (g == 2);
            img_count = (poke && g == 2) ? IMG_W'(5) : IMG_W'(n);
            #1;
            if (g == 0) chk(in_ready == 1'b1, "R2 ready after start", 64'(in_ready), 64'd1);
            if (prev_stall) begin
                chk(out_valid == 1'b1, "R6 valid held", 64'(out_valid), 64'd1);
                chk(out_data == prev_data, "R6 data held", 64'(out_data), 64'(prev_data));
            end
            prev_stall = out_valid && !out_ready;
            prev_data  = out_data;
            if (out_valid && !out_ready)
                chk(in_ready == 1'b0, "R6 no input while stalled", 64'(in_ready), 64'd0);
            if (out_valid && out_ready) begin
                chk(out_data == window(img_out, w), "R3 R7 window contents",
                    64'(out_data), 64'(window(img_out, w)));
                acc = (img_in == img_out) ? p : IN_W;
                chk(acc == KW + w, "R4 R5 pixels before window", 64'(acc), 64'(KW + w));
                if (timing && w == OUT_W - 1)
                    chk(g - first_in + 1 == KW + OUT_W, "R9 cycles per image",
                        64'(g - first_in + 1), 64'(KW + OUT_W));
                w++;
                if (w == OUT_W) begin
                    w = 0;
                    img_out++;
                end
            end
            if (in_valid && in_ready) begin
                if (p == 0) first_in = g;
                p++;
                if (p == IN_W) begin
                    p = 0;
                    img_in++;
                end
            end
            g++;
            @(negedge clk);
        end
        start = 1'b0;
        in_valid = 1'b1;
        out_ready = 1'b1;
        if (g >= 3000) chk(1'b0, "R5 run stalled", 64'(img_out), 64'(n));
        @(negedge clk);
        @(negedge clk);
        #1;
        chk(in_ready == 1'b0, poke ? "R10 idle after latched count" : "R8 idle in_ready",
            64'(in_ready), 64'd0);
        chk(out_valid == 1'b0, "R8 idle out_valid", 64'(out_valid), 64'd0);
        in_valid = 1'b0;
        out_ready = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(in_ready == 1'b0, "R1 in_ready in reset", 64'(in_ready), 64'd0);
        chk(out_valid == 1'b0, "R1 out_valid in reset", 64'(out_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b0, "R1 in_ready after reset", 64'(in_ready), 64'd0);
        chk(out_valid == 1'b0, "R1 out_valid after reset", 64'(out_valid), 64'd0);

        // R2: zero count leaves the block idle
        start = 1'b1;
        img_count = '0;
        in_valid = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
        chk(in_ready == 1'b0, "R2 zero count ignored", 64'(in_ready), 64'd0);
        in_valid = 1'b0;

        run(2, 0, 1'b0, 1'b1);
        run(3, 1, 1'b0, 1'b0);
        run(2, 2, 1'b0, 1'b0);
        run(2, 3, 1'b0, 1'b0);
        run(1, 1, 1'b1, 1'b0);
        run(1, 0, 1'b0, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 10);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule